// File: doc/BRIEF.md
# Control Endpoint Receive Status Register

This block keeps the receive status of a USB device's control endpoint. A packet engine ahead of it reports decoded token events (SETUP, OUT, IN), streams the payload bytes of each DATA packet, and marks the packet's end together with its data toggle. Three mode inputs steer how OUT traffic is handled: a stall flag, an accept-OUT flag and a status-OUT flag. From these events the block maintains an 8-bit status word that firmware can read and clear. It also decides which payload bytes go into the shared 8-byte endpoint FIFO and at which address, and it blocks firmware writes to that FIFO while SETUP data is being held.

A completed DATA packet that updates the status word raises a one-cycle endpoint interrupt. The byte count stored in the word includes the two CRC bytes. A packet that follows SETUP is always taken. A packet that follows OUT is counted, stored or dropped depending on the three mode inputs.

Top module: `ep0rx_status`

## Requirements
- R1: After reset, the status word is 0x00, `ep0_irq` is 0 and `fifo_we` is 0.
- R2: A pulse on `cpu_wr` clears bit 0 (SETUP seen), bit 1 (OUT seen), bit 2 (IN seen) and bits 7:4 (count). Bit 3 (toggle) keeps its value. R3 and R11 limit this rule.
- R3: A SETUP token (`tok_kind` 2'b00) sets bit 0. From the cycle after that token until the end of the DATA packet that follows it, `cpu_wr` leaves bit 0 set.
- R4: On a token with `tok_valid` high and code OUT (2'b01) or IN (2'b10), bit 1 becomes 1 only for OUT and bit 2 becomes 1 only for IN. A SETUP token clears both bits. Code 2'b11 is ignored.
- R5: `fw_wr_grant` equals `fw_wr_req` while bit 0 is 0, and it is 0 while bit 0 is 1.
- R6: For a DATA packet that follows SETUP, the count and the toggle are always updated, and every payload byte within FIFO range is written.
- R7: For a DATA packet that follows OUT, the count and the toggle are updated only when `mode_stall` is 0 and at least one of `mode_out_en` and `mode_out_status` is 1. Otherwise the word is unchanged.
- R8: A payload byte after OUT drives `fifo_we` only when `mode_out_en` is 1, `mode_stall` is 0 and `mode_out_status` is 0.
- R9: The stored count equals the number of payload bytes plus 2, capped at 15. The payload byte with index k is written to address k. Only indices 0 to 7 are written.
- R10: When `pkt_end` updates the word at clock edge k, `ep0_irq` is high for exactly the cycle that follows edge k+1. A packet end that updates nothing raises no interrupt.
- R11: When `cpu_wr` coincides with a token or with an updating packet end, the bits that the hardware event sets take the hardware value. The other clearable bits are cleared.
- R12: A `pkt_end` with no open DATA stage, such as one after an IN token, changes nothing and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token for endpoint 0 decoded this cycle |
| tok_kind | input | 2 | Token code: 00 SETUP, 01 OUT, 10 IN, 11 ignored |
| byte_valid | input | 1 | One payload byte of the current DATA packet |
| byte_data | input | 8 | Payload byte value |
| pkt_end | input | 1 | DATA packet finished, CRC good |
| pkt_toggle | input | 1 | Data toggle of the finished packet |
| mode_stall | input | 1 | Endpoint stalled |
| mode_out_en | input | 1 | OUT data accepted |
| mode_out_status | input | 1 | OUT used as status stage only |
| cpu_wr | input | 1 | Firmware write to the status word |
| fw_wr_req | input | 1 | Firmware request to write the FIFO |
| stat | output | 8 | Status word {count, toggle, IN, OUT, SETUP} |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_addr | output | 3 | FIFO write address |
| fifo_wdata | output | 8 | FIFO write data |
| fw_wr_grant | output | 1 | Firmware FIFO write allowed |
| ep0_irq | output | 1 | Endpoint interrupt pulse |

## Verification
A wrong DATA stage shows first at `fifo_we`, in the same cycle as the first payload byte. It shows again one edge after `pkt_end`, as a wrong count or toggle in `stat`. A wrong protection window for bit 0 shows at `stat` bit 0 and at `fw_wr_grant` one edge after a `cpu_wr`. A lost or extra update pulse shows at `ep0_irq` two edges after the packet end.

// File: rtl/ep0rx_pkg.sv
package ep0rx_pkg;

  typedef enum logic [1:0] {
    TOK_SETUP = 2'b00,
    TOK_OUT   = 2'b01,
    TOK_IN    = 2'b10,
    TOK_RSVD  = 2'b11
  } tok_e;

  typedef enum logic [1:0] {
    STG_IDLE  = 2'b00,
    STG_SETUP = 2'b01,
    STG_OUT   = 2'b10
  } stage_e;

  localparam int unsigned BIT_SETUP = 0;
  localparam int unsigned BIT_OUT   = 1;
  localparam int unsigned BIT_IN    = 2;
  localparam int unsigned BIT_TOG   = 3;
  localparam int unsigned CNT_LSB   = 4;

  // OUT packet may refresh count and toggle
  function automatic logic out_count_ok(input logic stall, input logic out_en,
                                        input logic out_status);
    return !stall && (out_en || out_status);
  endfunction

  // OUT packet payload may land in the FIFO
  function automatic logic out_store_ok(input logic stall, input logic out_en,
                                        input logic out_status);
    return out_en && !stall && !out_status;
  endfunction

  // stored count: payload bytes plus trailing CRC bytes
  function automatic int unsigned with_crc(input int unsigned nbytes,
                                           input int unsigned crc_bytes);
    return nbytes + crc_bytes;
  endfunction

  function automatic logic tok_is_real(input logic [1:0] kind);
    return kind != TOK_RSVD;
  endfunction

endpackage

// File: rtl/ep0rx_stage.sv
module ep0rx_stage
  import ep0rx_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned CRC_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_valid,
  input  logic [1:0]       tok_kind,
  input  logic             byte_valid,
  input  logic             pkt_end,
  output stage_e           stage,
  output logic [CNT_W-1:0] byte_idx,
  output logic [CNT_W-1:0] pkt_bytes
);
  localparam logic [CNT_W-1:0] DATA_MAX = CNT_W'((2 ** CNT_W) - 1 - CRC_BYTES);

  logic tok_hit;
  logic can_count;

  assign tok_hit   = tok_valid && tok_is_real(tok_kind);
  assign can_count = byte_valid && (byte_idx != DATA_MAX);
  assign pkt_bytes = can_count ? byte_idx + CNT_W'(1) : byte_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage    <= STG_IDLE;
      byte_idx <= '0;
    end else if (tok_hit) begin
      byte_idx <= '0;
      case (tok_kind)
        TOK_SETUP: stage <= STG_SETUP;
        TOK_OUT:   stage <= STG_OUT;
        default:   stage <= STG_IDLE;
      endcase
    end else if (pkt_end) begin
      stage    <= STG_IDLE;
      byte_idx <= '0;
    end else if (can_count) begin
      byte_idx <= byte_idx + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ep0rx_fifo_gate.sv
module ep0rx_fifo_gate
  import ep0rx_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  stage_e            stage,
  input  logic              byte_valid,
  input  logic [CNT_W-1:0]  byte_idx,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              mode_stall,
  input  logic              mode_out_en,
  input  logic              mode_out_status,
  input  logic              fw_wr_req,
  input  logic              setup_flag,
  output logic              fifo_we,
  output logic [ADDR_W-1:0] fifo_addr,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              fw_wr_grant
);
  logic in_range;
  logic accept;

  assign in_range = 32'(byte_idx) < DEPTH;

  always_comb begin
    case (stage)
      STG_SETUP: accept = 1'b1;
      STG_OUT:   accept = out_store_ok(mode_stall, mode_out_en, mode_out_status);
      default:   accept = 1'b0;
    endcase
  end

  assign fifo_we     = byte_valid && accept && in_range;
  assign fifo_addr   = byte_idx[ADDR_W-1:0];
  assign fifo_wdata  = byte_data;
  assign fw_wr_grant = fw_wr_req && !setup_flag;
endmodule

// File: rtl/ep0rx_status_reg.sv
module ep0rx_status_reg
  import ep0rx_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned CRC_BYTES = 2,
  localparam int unsigned STAT_W   = CNT_LSB + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic              pkt_end,
  input  logic              pkt_toggle,
  input  stage_e            stage,
  input  logic [CNT_W-1:0]  pkt_bytes,
  input  logic              mode_stall,
  input  logic              mode_out_en,
  input  logic              mode_out_status,
  input  logic              cpu_wr,
  output logic [STAT_W-1:0] stat_q,
  output logic              upd,
  output logic              irq
);
  logic              tok_hit;
  logic              upd_q;
  logic [CNT_W-1:0]  cnt_new;
  logic [STAT_W-1:0] stat_d;

  assign tok_hit = tok_valid && tok_is_real(tok_kind);
  assign cnt_new = CNT_W'(with_crc(32'(pkt_bytes), CRC_BYTES));

  always_comb begin
    case (stage)
      STG_SETUP: upd = pkt_end;
      STG_OUT:   upd = pkt_end && out_count_ok(mode_stall, mode_out_en, mode_out_status);
      default:   upd = 1'b0;
    endcase
  end

  always_comb begin
    stat_d = stat_q;
    if (cpu_wr) begin
      if (stage != STG_SETUP) stat_d[BIT_SETUP] = 1'b0;
      stat_d[BIT_OUT] = 1'b0;
      stat_d[BIT_IN]  = 1'b0;
      stat_d[STAT_W-1:CNT_LSB] = '0;
    end
    if (tok_hit) begin
      stat_d[BIT_OUT] = (tok_kind == TOK_OUT);
      stat_d[BIT_IN]  = (tok_kind == TOK_IN);
      if (tok_kind == TOK_SETUP) stat_d[BIT_SETUP] = 1'b1;
    end
    if (upd) begin
      stat_d[BIT_TOG] = pkt_toggle;
      stat_d[STAT_W-1:CNT_LSB] = cnt_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      upd_q  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      upd_q  <= upd;
      irq    <= upd_q;
    end
  end
endmodule

// File: rtl/ep0rx_status.sv
module ep0rx_status
  import ep0rx_pkg::*;
#(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned CRC_BYTES = 2,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned ADDR_W   = $clog2(DEPTH),
  localparam int unsigned STAT_W   = CNT_LSB + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              pkt_end,
  input  logic              pkt_toggle,
  input  logic              mode_stall,
  input  logic              mode_out_en,
  input  logic              mode_out_status,
  input  logic              cpu_wr,
  input  logic              fw_wr_req,
  output logic [STAT_W-1:0] stat,
  output logic              fifo_we,
  output logic [ADDR_W-1:0] fifo_addr,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              fw_wr_grant,
  output logic              ep0_irq
);
  // internal events brought out for the checker
  stage_e           stage;
  logic [CNT_W-1:0] byte_idx;
  logic [CNT_W-1:0] pkt_bytes;
  logic             upd;

  ep0rx_stage #(.CNT_W(CNT_W), .CRC_BYTES(CRC_BYTES)) u_stage (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .byte_valid(byte_valid), .pkt_end(pkt_end), .stage(stage),
    .byte_idx(byte_idx), .pkt_bytes(pkt_bytes)
  );

  ep0rx_fifo_gate #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_gate (
    .stage(stage), .byte_valid(byte_valid), .byte_idx(byte_idx),
    .byte_data(byte_data), .mode_stall(mode_stall), .mode_out_en(mode_out_en),
    .mode_out_status(mode_out_status), .fw_wr_req(fw_wr_req),
    .setup_flag(stat[BIT_SETUP]), .fifo_we(fifo_we), .fifo_addr(fifo_addr),
    .fifo_wdata(fifo_wdata), .fw_wr_grant(fw_wr_grant)
  );

  ep0rx_status_reg #(.CNT_W(CNT_W), .CRC_BYTES(CRC_BYTES)) u_reg (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .pkt_end(pkt_end), .pkt_toggle(pkt_toggle), .stage(stage),
    .pkt_bytes(pkt_bytes), .mode_stall(mode_stall), .mode_out_en(mode_out_en),
    .mode_out_status(mode_out_status), .cpu_wr(cpu_wr), .stat_q(stat),
    .upd(upd), .irq(ep0_irq)
  );
endmodule

// File: rtl/ep0rx_status_chk.sv
module ep0rx_status_chk
  import ep0rx_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned CRC_BYTES = 2,
  localparam int unsigned STAT_W   = CNT_LSB + CNT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tok_valid,
  input logic [1:0]        tok_kind,
  input logic              cpu_wr,
  input logic              fw_wr_req,
  input logic              mode_stall,
  input logic              mode_out_en,
  input logic              mode_out_status,
  input logic [STAT_W-1:0] stat,
  input logic              fifo_we,
  input logic              fw_wr_grant,
  input logic              ep0_irq,
  input logic [1:0]        stage,
  input logic              upd
);
  AST_TOGGLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !upd) |=> (stat[BIT_TOG] == $past(stat[BIT_TOG]))); // R2

  AST_SETUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == STG_SETUP && stat[BIT_SETUP]) |=> stat[BIT_SETUP]); // R3

  AST_IN_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TOK_IN) |=> (stat[BIT_IN] && !stat[BIT_OUT])); // R4

  AST_FW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    stat[BIT_SETUP] |-> !fw_wr_grant); // R5

  AST_FW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat[BIT_SETUP] && fw_wr_req) |-> fw_wr_grant); // R5

  AST_OUT_STORE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we && stage == STG_OUT) |-> (mode_out_en && !mode_stall && !mode_out_status)); // R8

  AST_NO_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == STG_IDLE) |-> !fifo_we); // R12

  AST_COUNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (32'(stat[STAT_W-1:CNT_LSB]) >= CRC_BYTES)); // R9

  AST_IRQ_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> ##2 ep0_irq); // R10

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ep0_irq && !$past(upd)) |=> !ep0_irq); // R10
endmodule

bind ep0rx_status ep0rx_status_chk #(.CNT_W(CNT_W), .CRC_BYTES(CRC_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
  .cpu_wr(cpu_wr), .fw_wr_req(fw_wr_req), .mode_stall(mode_stall),
  .mode_out_en(mode_out_en), .mode_out_status(mode_out_status), .stat(stat),
  .fifo_we(fifo_we), .fw_wr_grant(fw_wr_grant), .ep0_irq(ep0_irq),
  .stage(stage), .upd(upd)
);

// File: tb/test_ep0rx_status.sv
module test_ep0rx_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_valid = 1'b0;
  logic [1:0] tok_kind = 2'b00;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       pkt_end = 1'b0;
  logic       pkt_toggle = 1'b0;
  logic       mode_stall = 1'b0;
  logic       mode_out_en = 1'b0;
  logic       mode_out_status = 1'b0;
  logic       cpu_wr = 1'b0;
  logic       fw_wr_req = 1'b0;
  logic [7:0] stat;
  logic       fifo_we;
  logic [2:0] fifo_addr;
  logic [7:0] fifo_wdata;
  logic       fw_wr_grant;
  logic       ep0_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] K_SETUP = 2'b00, K_OUT = 2'b01, K_IN = 2'b10;

  ep0rx_status i_ep0rx_status (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send_token(input logic [1:0] k, input bit with_wr);
    tok_valid = 1'b1; tok_kind = k; cpu_wr = with_wr;
    step();
    tok_valid = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic cpu_write();
    cpu_wr = 1'b1;
    step();
    cpu_wr = 1'b0;
  endtask

  task automatic send_bytes(input int n, input bit store, input string req);
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1; byte_data = 8'(8'h30 + i);
      #1;
      chk({req, " fifo_we"}, int'(fifo_we), int'(store && i < 8));
      if (store && i < 8) begin
        chk({req, " fifo_addr"}, int'(fifo_addr), i);
        chk({req, " fifo_wdata"}, int'(fifo_wdata), 8'h30 + i);
      end
      step();
    end
    byte_valid = 1'b0;
  endtask

  // packet end; checks word after the edge and the interrupt timing
  task automatic end_pkt(input bit tog, input bit with_wr, input int exp_stat,
                         input bit exp_irq, input string req);
    pkt_end = 1'b1; pkt_toggle = tog; cpu_wr = with_wr;
    step();
    pkt_end = 1'b0; cpu_wr = 1'b0;
    chk({req, " stat"}, int'(stat), exp_stat);
    chk("R10 irq same cycle", int'(ep0_irq), 0);
    step();
    chk("R10 irq pulse", int'(ep0_irq), int'(exp_irq));
    step();
    chk("R10 irq end", int'(ep0_irq), 0);
  endtask

  task automatic t_reset();
    step(); step();
    chk("R1 stat", int'(stat), 0);
    chk("R1 irq", int'(ep0_irq), 0);
    chk("R1 fifo_we", int'(fifo_we), 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_setup();
    send_token(K_SETUP, 1'b0);
    chk("R3 setup bit", int'(stat), 8'h01);
    cpu_write();
    chk("R3 protected", int'(stat), 8'h01);
    fw_wr_req = 1'b1; #1;
    chk("R5 lock", int'(fw_wr_grant), 0);
    fw_wr_req = 1'b0;
    send_bytes(8, 1'b1, "R6 setup data");
    end_pkt(1'b0, 1'b0, 8'hA1, 1'b1, "R9 setup count");
    cpu_write();
    chk("R2 clear", int'(stat), 8'h00);
    fw_wr_req = 1'b1; #1;
    chk("R5 open", int'(fw_wr_grant), 1);
    fw_wr_req = 1'b0;
  endtask

  task automatic t_out_accept();
    mode_out_en = 1'b1;
    send_token(K_OUT, 1'b0);
    chk("R4 out bit", int'(stat), 8'h02);
    send_bytes(3, 1'b1, "R8 out store");
    end_pkt(1'b1, 1'b0, 8'h5A, 1'b1, "R7 out update");
    cpu_write();
    chk("R2 toggle kept", int'(stat), 8'h08);
  endtask

  task automatic t_out_status();
    mode_out_en = 1'b0; mode_out_status = 1'b1;
    send_token(K_OUT, 1'b0);
    send_bytes(2, 1'b0, "R8 status no store");
    end_pkt(1'b0, 1'b0, 8'h42, 1'b1, "R7 status count");
  endtask

  task automatic t_out_blocked();
    mode_out_status = 1'b0; mode_out_en = 1'b1; mode_stall = 1'b1;
    send_token(K_OUT, 1'b0);
    send_bytes(2, 1'b0, "R8 stall no store");
    end_pkt(1'b1, 1'b0, 8'h42, 1'b0, "R7 stall no update");
    mode_stall = 1'b0; mode_out_en = 1'b0;
    send_token(K_OUT, 1'b0);
    send_bytes(1, 1'b0, "R8 disabled no store");
    end_pkt(1'b1, 1'b0, 8'h42, 1'b0, "R7 disabled no update");
  endtask

  task automatic t_in_and_rsvd();
    send_token(K_IN, 1'b0);
    chk("R4 in bit", int'(stat), 8'h44);
    send_token(2'b11, 1'b0);
    chk("R4 reserved ignored", int'(stat), 8'h44);
    end_pkt(1'b1, 1'b0, 8'h44, 1'b0, "R12 stray end");
  endtask

  task automatic t_overflow();
    send_token(K_SETUP, 1'b0);
    send_bytes(10, 1'b1, "R9 overflow");
    end_pkt(1'b1, 1'b0, 8'hC9, 1'b1, "R9 count 12");
    cpu_write();
    chk("R2 after setup done", int'(stat), 8'h08);
  endtask

  task automatic t_collide();
    mode_out_en = 1'b1;
    send_token(K_OUT, 1'b0);
    chk("R4 out", int'(stat), 8'h0A);
    send_bytes(1, 1'b1, "R8 one byte");
    end_pkt(1'b0, 1'b1, 8'h30, 1'b1, "R11 end with write");
    send_token(K_IN, 1'b1);
    chk("R11 token with write", int'(stat), 8'h04);
    mode_out_en = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0x0 expected 0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_setup();
    t_out_accept();
    t_out_status();
    t_out_blocked();
    t_in_and_rsvd();
    t_overflow();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule